// File: doc/BRIEF.md
# Receive Frame Status Capture Register

This block sits behind a bit-synchronous (HDLC-style) serial receiver. It holds the status of the most recently completed frame. The bit decoder pushes received characters into a small receive buffer. Each character carries a data byte, an end-of-message marker and five error flags. The CPU pops characters from the buffer through a register read. While the characters of a frame are popped, their error flags build up in a live status register. When the CPU pops the character marked end-of-message, the live flags and that character's own flags go into the frame status register in one step, and the live register clears. Software clears frame status bits by writing ones to them. Only the end-of-message bit can raise the interrupt output.

The CPU port has separate read and write strobes, so a read and a write can happen in the same cycle. Receiver commands arrive as single-cycle pulses: enable, disable, receiver reset and channel reset. A system-stop level holds all status at zero.

Top module: `rx_frame_status`

Register map (2-bit address):
- 0: receive data. A read pops the buffer head. Writes are ignored.
- 1: live status. Read-only.
- 2: frame status. Read, and write 1 to clear.
- 3: control. Bit 0 is the receiver-enabled flag. Read-only.

Status bit layout, used by the flag input, the live register and the frame register alike:
- bit 7 (flag bit 5): end-of-message
- bit 6 (flag bit 4): short frame
- bit 5 (flag bit 3): abort
- bit 4 (flag bit 2): residual bit
- bit 3 (flag bit 1): overrun
- bit 2 (flag bit 0): CRC error

## Requirements
- R1: Reads of addresses 1 and 2 return the six status bits in positions 7..2, laid out as listed above. Bits 1 and 0 always read 0. Address 3 returns the enable flag in bit 0 and zeros in all other bits.
- R2: A read of address 0 whose head character has its end-of-message flag set has these effects from the next cycle on. Frame status equals the live status ORed with that character's flags, so bit 7 is set. Live status reads 0.
- R3: A read of address 0 whose head character is not end-of-message ORs that character's flags into live status. Frame status is left unchanged.
- R4: A write to address 2 clears each frame status bit whose data bit is 1 and keeps each bit whose data bit is 0. Writes to addresses 0, 1 and 3 change no register.
- R5: If a capture (R2) and a write to address 2 fall in the same cycle, the capture wins and the write is dropped.
- R6: A receiver reset or channel reset pulse empties the buffer and clears live and frame status. A channel reset also disables the receiver.
- R7: While sys_stop_i is high, live and frame status stay 0, and reads of end-of-message characters capture nothing. Data still pops.
- R8: irq_o is high exactly when frame status bit 7 is set and eom_irq_en_i is high. No other status bit affects it.
- R9: The enable flag is set by an enable pulse and cleared by a disable pulse or a channel reset. If enable and disable arrive together, disable wins. Writes to address 3 have no effect.
- R10: The buffer holds DEPTH characters (default 4) and returns them in arrival order. A push is ignored while the receiver is disabled or the buffer is full.
- R11: A read of address 0 with an empty buffer returns 0 and changes no status.
- R12: After hardware reset, every register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | DATA_W | Character data |
| push_flags_i | input | 6 | Character flags: end-of-message in bit 5, errors in bits 4..0 |
| rd_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, valid in the cycle of rd_i |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| cmd_rx_en_i | input | 1 | Receiver enable command pulse |
| cmd_rx_dis_i | input | 1 | Receiver disable command pulse |
| cmd_rx_rst_i | input | 1 | Receiver reset command pulse |
| cmd_ch_rst_i | input | 1 | Channel reset command pulse |
| sys_stop_i | input | 1 | System stop level |
| eom_irq_en_i | input | 1 | End-of-message interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The key collision is the CPU popping an end-of-message character in the same cycle as it writes ones to the frame status register. The split read and write strobes make that collision reachable. A directed case queues an end-of-message character and then issues both accesses in one cycle with an all-ones clear mask. The frame status read afterwards must hold the newly captured flags. The random phase issues reads and writes independently, so the collision recurs many times. There it is judged against a bench model in which capture overrides the clear.

// File: rtl/rx_fs_pkg.sv
package rx_fs_pkg;
  localparam int FLAG_W = 6;
  localparam int B_EOM  = 5;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 2'd0,
    A_LIVE  = 2'd1,
    A_FRAME = 2'd2,
    A_CTRL  = 2'd3
  } reg_addr_e;

  typedef logic [FLAG_W-1:0] stat_t;
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int FLAG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [FLAG_W-1:0] push_flags_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [FLAG_W-1:0] head_flags_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + FLAG_W;

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic [ENT_W-1:0] mem [DEPTH];
  logic             do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[i] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(i)) mem[i] <= {push_flags_i, push_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_data_o  = mem[rd_ptr_q][DATA_W-1:0];
  assign head_flags_o = mem[rd_ptr_q][ENT_W-1:DATA_W];

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/rx_live_stat.sv
module rx_live_stat
  import rx_fs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  pop_i,
  input  stat_t flags_i,
  output stat_t live_o
);
  stat_t live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        live_q <= '0;
    else if (clear_i)                   live_q <= '0;
    else if (pop_i && flags_i[B_EOM])   live_q <= '0;
    else if (pop_i)                     live_q <= live_q | flags_i;
  end

  assign live_o = live_q;

  p_accum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flags_i[B_EOM] && !clear_i) |=> ((live_o & $past(flags_i)) == $past(flags_i)));
endmodule

// File: rtl/rx_frame_stat.sv
module rx_frame_stat
  import rx_fs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  capture_i,
  input  stat_t cap_val_i,
  input  logic  w1c_i,
  input  stat_t w1c_mask_i,
  output stat_t frame_o
);
  stat_t frame_q;

  // capture overrides a coincident write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frame_q <= '0;
    else if (clear_i)   frame_q <= '0;
    else if (capture_i) frame_q <= cap_val_i;
    else if (w1c_i)     frame_q <= frame_q & ~w1c_mask_i;
  end

  assign frame_o = frame_q;

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i && !capture_i && !clear_i) |=> frame_o == ($past(frame_o) & ~$past(w1c_mask_i)));
  p_capture_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && w1c_i && !clear_i) |=> frame_o == $past(cap_val_i));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> frame_o == '0);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rx_fs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [5:0]        push_flags_i,
  input  logic              rd_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cmd_rx_en_i,
  input  logic              cmd_rx_dis_i,
  input  logic              cmd_rx_rst_i,
  input  logic              cmd_ch_rst_i,
  input  logic              sys_stop_i,
  input  logic              eom_irq_en_i,
  output logic              irq_o
);
  logic        rx_en_q, clr, stat_clr, fifo_empty, fifo_full, pop, capture, w1c;
  logic [DATA_W-1:0] head_data;
  stat_t       head_flags, live_q, frame_q;

  assign clr      = cmd_rx_rst_i || cmd_ch_rst_i;
  assign stat_clr = clr || sys_stop_i;
  assign pop      = rd_i && (rd_addr_i == A_DATA) && !fifo_empty && !clr;
  assign capture  = pop && head_flags[B_EOM] && !sys_stop_i;
  assign w1c      = wr_i && (wr_addr_i == A_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            rx_en_q <= 1'b0;
    else if (cmd_ch_rst_i || cmd_rx_dis_i)  rx_en_q <= 1'b0;
    else if (cmd_rx_en_i)                   rx_en_q <= 1'b1;
  end

  rx_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FLAG_W(FLAG_W)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (clr),
    .push_i       (push_i && rx_en_q),
    .push_data_i  (push_data_i),
    .push_flags_i (push_flags_i),
    .pop_i        (pop),
    .head_data_o  (head_data),
    .head_flags_o (head_flags),
    .empty_o      (fifo_empty),
    .full_o       (fifo_full)
  );

  rx_live_stat u_live (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (stat_clr),
    .pop_i   (pop),
    .flags_i (head_flags),
    .live_o  (live_q)
  );

  rx_frame_stat u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (stat_clr),
    .capture_i  (capture),
    .cap_val_i  (live_q | head_flags),
    .w1c_i      (w1c),
    .w1c_mask_i (wr_data_i[7:2]),
    .frame_o    (frame_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_i) begin
      case (rd_addr_i)
        A_DATA:  rd_data_o = fifo_empty ? '0 : head_data;
        A_LIVE:  rd_data_o = DATA_W'({live_q, 2'b00});
        A_FRAME: rd_data_o = DATA_W'({frame_q, 2'b00});
        default: rd_data_o = DATA_W'(rx_en_q);
      endcase
    end
  end

  assign irq_o = eom_irq_en_i && frame_q[B_EOM];

  p_live_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> live_q == '0);
  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_stop_i |=> (frame_q == '0 && live_q == '0));
  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(irq_o) && irq_o && $stable(eom_irq_en_i)) |-> $past(capture));
  p_en_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cmd_rx_en_i && !cmd_rx_dis_i && !cmd_ch_rst_i) |=> $stable(rx_en_q));
  p_empty_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_addr_i == A_DATA && fifo_empty && !wr_i && !stat_clr)
      |=> ($stable(live_q) && $stable(frame_q)));
  p_full_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full && !pop && !clr) |=> fifo_full);
endmodule

// File: tb/rx_frame_status_bench.sv
module rx_frame_status_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push, rd, wr, c_en, c_dis, c_rrst, c_crst, stop, ie;
  logic [7:0] pdata, wdata, rdata;
  logic [5:0] pflags;
  logic [1:0] raddr, waddr;
  logic irq;

  int checks = 0, errors = 0;
  string tag = "";

  logic [13:0] q[$];
  logic [5:0]  m_live, m_frame;
  logic        m_en;

  always #10 clk = ~clk;

  rx_frame_status u_rx_frame_status (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata), .push_flags_i(pflags),
    .rd_i(rd), .rd_addr_i(raddr), .rd_data_o(rdata), .wr_i(wr), .wr_addr_i(waddr),
    .wr_data_i(wdata), .cmd_rx_en_i(c_en), .cmd_rx_dis_i(c_dis), .cmd_rx_rst_i(c_rrst),
    .cmd_ch_rst_i(c_crst), .sys_stop_i(stop), .eom_irq_en_i(ie), .irq_o(irq));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return (q.size() > 0) ? q[0][7:0] : 8'h00;
      2'd1: return {m_live, 2'b00};
      2'd2: return {m_frame, 2'b00};
      default: return {7'b0, m_en};
    endcase
  endfunction

  function automatic string auto_tag(logic [1:0] a);
    case (a)
      2'd0: return "R10";
      2'd1: return "R3";
      2'd2: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic idle();
    push = 0; rd = 0; wr = 0; c_en = 0; c_dis = 0; c_rrst = 0; c_crst = 0;
    pdata = 0; pflags = 0; raddr = 0; waddr = 0; wdata = 0;
  endtask

  // inputs must already be set; samples before the edge, then updates the model
  task automatic step();
    logic [13:0] head;
    bit pop, en_pre, full_pre;
    #5;
    chk("R8", {7'b0, irq}, {7'b0, ie & m_frame[5]});
    if (rd) chk(tag != "" ? tag : auto_tag(raddr), rdata, exp_read(raddr));
    en_pre = m_en;
    full_pre = (q.size() >= DEPTH);
    if (c_rrst || c_crst) begin
      q.delete(); m_live = 0; m_frame = 0;
      if (c_crst || c_dis) m_en = 0; else if (c_en) m_en = 1;
    end else begin
      pop = rd && raddr == 2'd0 && q.size() > 0;
      head = pop ? q.pop_front() : 14'h0;
      if (stop) begin
        m_live = 0; m_frame = 0;
      end else if (pop && head[13]) begin
        m_frame = m_live | head[13:8]; m_live = 0;
      end else begin
        if (pop) m_live = m_live | head[13:8];
        if (wr && waddr == 2'd2) m_frame = m_frame & ~wdata[7:2];
      end
      if (push && en_pre && !full_pre) q.push_back({pflags, pdata});
      if (c_dis) m_en = 0; else if (c_en) m_en = 1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(logic [1:0] a, string t);
    tag = t; rd = 1; raddr = a; step(); tag = "";
  endtask

  task automatic do_push(logic [7:0] d, logic [5:0] f);
    push = 1; pdata = d; pflags = f; step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(); stop = 0; ie = 0;
    q.delete(); m_live = 0; m_frame = 0; m_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    for (int a = 0; a < 4; a++) do_read(a[1:0], "R12");

    // frame of three characters
    c_en = 1; step();
    do_read(2'd3, "R9");
    do_push(8'h11, 6'b000001);
    do_push(8'h22, 6'b000010);
    do_push(8'h33, 6'b110000);
    do_read(2'd0, "R10");
    do_read(2'd0, "R10");
    do_read(2'd1, "R3");
    do_read(2'd2, "R3");
    do_read(2'd0, "R2");
    do_read(2'd2, "R2");
    do_read(2'd1, "R2");
    ie = 1; step(); ie = 0; step();
    do_read(2'd1, "R1");

    // write-one-to-clear and ignored writes
    wr = 1; waddr = 2'd2; wdata = 8'h84; step();
    do_read(2'd2, "R4");
    wr = 1; waddr = 2'd3; wdata = 8'h00; step();
    wr = 1; waddr = 2'd1; wdata = 8'hFF; step();
    wr = 1; waddr = 2'd0; wdata = 8'hFF; step();
    do_read(2'd3, "R4");
    do_read(2'd2, "R4");

    // capture and clear in one cycle
    do_push(8'h44, 6'b101000);
    rd = 1; raddr = 2'd0; wr = 1; waddr = 2'd2; wdata = 8'hFF; tag = "R5"; step(); tag = "";
    do_read(2'd2, "R5");

    // empty read
    do_read(2'd0, "R11");
    do_read(2'd2, "R11");

    // full buffer
    for (int i = 0; i < 5; i++) do_push(8'h50 + 8'(i), 6'b000100);
    for (int i = 0; i < 5; i++) do_read(2'd0, "R10");
    do_read(2'd1, "R10");

    // disabled receiver drops pushes
    c_dis = 1; c_en = 1; step();
    do_read(2'd3, "R9");
    do_push(8'h66, 6'b100000);
    do_read(2'd0, "R10");

    // resets
    c_en = 1; step();
    do_push(8'h70, 6'b000001); do_push(8'h71, 6'b100010);
    do_read(2'd0, "R6");
    c_rrst = 1; step();
    do_read(2'd1, "R6"); do_read(2'd0, "R6"); do_read(2'd3, "R6");
    do_push(8'h72, 6'b100001); do_read(2'd0, "R6");
    do_read(2'd2, "R6");
    c_crst = 1; step();
    do_read(2'd2, "R6"); do_read(2'd3, "R6");

    // system stop
    c_en = 1; step();
    do_push(8'h80, 6'b000100); do_push(8'h81, 6'b100001);
    stop = 1;
    do_read(2'd0, "R7"); do_read(2'd0, "R7");
    do_read(2'd2, "R7"); do_read(2'd1, "R7");
    stop = 0;
    do_read(2'd2, "R7");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      push = (r < 45);
      pdata = 8'($urandom);
      pflags = {($urandom_range(0, 3) == 0), 5'($urandom)};
      rd = ($urandom_range(0, 1) == 1);
      raddr = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0;
      wr = ($urandom_range(0, 4) == 0);
      waddr = ($urandom_range(0, 1) == 0) ? 2'd2 : 2'($urandom);
      wdata = 8'($urandom);
      c_en = ($urandom_range(0, 19) == 0);
      c_dis = ($urandom_range(0, 59) == 0);
      c_rrst = ($urandom_range(0, 149) == 0);
      c_crst = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 49) == 0) stop = ~stop;
      ie = ($urandom_range(0, 3) != 0);
      step();
    end
    stop = 0;
    for (int a = 0; a < 4; a++) do_read(a[1:0], "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule